// File: doc/BRIEF.md
# Track Command Packet Waveform Generator

This block turns a locomotive command (a 7-bit address, a direction flag and a 7-bit speed) into the bipolar waveform that carries both power and data on a two-rail model railway. It builds a frame from the command and sends it as a sequence of fixed-length unit intervals (UIs) on two complementary outputs, which control the legs of an H-bridge. A single clock-cycle divider sets the UI length.

A logical one is sent as two UIs and a logical zero as four. A new command is placed in a shadow register when a one-cycle strobe arrives. It reaches the transmitter only once the frame being sent has finished, so no frame is ever altered partway through. When no new command arrives, the active frame is sent again back to back, so the rails never lose power.

Top module: `track_pkt_gen`

## Requirements
- R1: A frame is sent in this order: a preamble of PREAMBLE_BITS (default 11) ones, a zero, the address octet, a zero, the command octet, a zero, the check octet, and a closing one. Each octet is sent most significant bit first.
- R2: The check octet is the bitwise XOR of the address octet and the command octet.
- R3: The address octet is a 0 in bit 7 followed by `addr` in bits 6:0. The command octet has `dir` in bit 7 and `speed` in bits 6:0.
- R4: A one bit is sent as two UIs, low then high. A zero bit is sent as four UIs: low, low, high, high.
- R5: Every UI lasts exactly UI_CYCLES clock cycles. A high level means `drv_a`=1 and `drv_b`=0. A low level means `drv_a`=0 and `drv_b`=1. The outputs follow the internal UI sequence one clock cycle later.
- R6: `drv_a` and `drv_b` are always complementary outside reset, and both change on the same clock edge.
- R7: A pulse on `update` captures `addr`, `dir` and `speed` into a shadow register. The frame being sent is not changed. The captured command takes effect from the frame that starts after the current frame's last UI. If several pulses arrive within one frame, the last one wins.
- R8: When no new command is pending, the active frame repeats with no gap between frames.
- R9: A synchronous reset (`rst_n` low) does the following:
  - sets the active command to address 0, direction 0, speed 0;
  - discards any pending command;
  - drives the low level;
  - restarts transmission at the first preamble UI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| update | input | 1 | One-cycle strobe that captures a new command |
| addr | input | 7 | Locomotive address |
| dir | input | 1 | Direction flag |
| speed | input | 7 | Speed value |
| drv_a | output | 1 | H-bridge leg A control, high for the high level |
| drv_b | output | 1 | H-bridge leg B control, always the inverse of `drv_a` |

## Verification
A wrong internal state shows up at the ports as a drive level that differs from the expected UI stream. A bad divider count makes a UI too short or too long, and the error is visible within one UI. A bad bit or phase position shifts every later UI of the frame. A bad shadow handover puts the wrong command into a frame, or changes a frame partway through, and the effect is seen at the latest by the end of the next frame. The bench compares every clock cycle of every frame against a stream built from the requirements, so any of these errors is caught within one frame.

// File: rtl/track_pkt_gen.sv
module track_pkt_gen #(
  parameter int UI_CYCLES     = 928,
  parameter int PREAMBLE_BITS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       update,
  input  logic [6:0] addr,
  input  logic       dir,
  input  logic [6:0] speed,
  output logic       drv_a,
  output logic       drv_b
);
  localparam int DIV_W      = (UI_CYCLES > 1) ? $clog2(UI_CYCLES) : 1;
  localparam int FRAME_BITS = PREAMBLE_BITS + 28;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(UI_CYCLES - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] div;
  logic [IDX_W-1:0] bit_idx;
  logic [1:0]       phase;
  logic [6:0]       sh_addr, act_addr;
  logic [7:0]       sh_cmd, act_cmd;
  logic             pend;

  logic [7:0]            addr_oct;
  logic [FRAME_BITS-1:0] frame;
  logic                  cur_bit, last_phase, level, tick, frame_end;

  assign addr_oct   = {1'b0, act_addr};
  assign frame      = {{PREAMBLE_BITS{1'b1}}, 1'b0, addr_oct, 1'b0, act_cmd,
                       1'b0, addr_oct ^ act_cmd, 1'b1};
  assign cur_bit    = frame[LAST_BIT - bit_idx];
  assign last_phase = cur_bit ? (phase == 2'd1) : (phase == 2'd3);
  assign level      = cur_bit ? phase[0] : phase[1];
  assign tick       = (div == DIV_LAST);
  assign frame_end  = tick && last_phase && (bit_idx == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div      <= '0;
      bit_idx  <= '0;
      phase    <= '0;
      sh_addr  <= '0;
      sh_cmd   <= '0;
      pend     <= 1'b0;
      act_addr <= '0;
      act_cmd  <= '0;
      drv_a    <= 1'b0;
      drv_b    <= 1'b1;
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        if (last_phase) begin
          phase   <= '0;
          bit_idx <= (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
        end else begin
          phase <= phase + 2'd1;
        end
      end
      if (update) begin
        sh_addr <= addr;
        sh_cmd  <= {dir, speed};
        pend    <= 1'b1;
      end else if (frame_end) begin
        pend <= 1'b0;
      end
      if (frame_end && pend) begin
        act_addr <= sh_addr;
        act_cmd  <= sh_cmd;
      end
      drv_a <= level;
      drv_b <= ~level;
    end
  end

  // R6
  drive_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_a != drv_b);

  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div <= DIV_LAST);

  // R5
  ui_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable({bit_idx, phase}));

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_bit |-> !phase[1]);

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable({act_addr, act_cmd}));

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> pend);
endmodule

// File: tb/sim_track_pkt_gen.sv
`timescale 1ns/1ps
module sim_track_pkt_gen;
  localparam int N = 4;

  logic clk = 1'b0, rst_n = 1'b0, update = 1'b0, dir = 1'b0;
  logic [6:0] addr = '0, speed = '0;
  logic drv_a, drv_b;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  track_pkt_gen #(.UI_CYCLES(N), .PREAMBLE_BITS(11)) u0 (
    .clk(clk), .rst_n(rst_n), .update(update), .addr(addr), .dir(dir),
    .speed(speed), .drv_a(drv_a), .drv_b(drv_b));

  // {addr, dir, speed}
  localparam logic [14:0] VEC [6] = '{
    {7'd3,   1'b1, 7'd5},
    {7'd127, 1'b1, 7'd127},
    {7'd85,  1'b0, 7'd42},
    {7'd1,   1'b0, 7'd127},
    {7'd0,   1'b0, 7'd0},
    {7'd64,  1'b1, 7'd1}
  };

  task automatic check_bit(input logic ok, input string what, input logic got, input logic exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  // Expects one whole frame carrying ev; nupd: 0 none, 1 one pulse, 2 two pulses (second wins)
  task automatic run_frame(input logic [14:0] ev, input int nupd, input logic [14:0] uv,
                           input string tag);
    logic [7:0] ao, co;
    logic [38:0] fb;
    logic lvl, f_got, f_exp;
    int ui, bad, cbad, f_ui;
    ao = {1'b0, ev[14:8]};
    co = ev[7:0];
    fb = {11'h7FF, 1'b0, ao, 1'b0, co, 1'b0, ao ^ co, 1'b1};
    ui = 0; bad = 0; cbad = 0; f_ui = -1; f_got = 1'b0; f_exp = 1'b0;
    for (int i = 38; i >= 0; i--) begin
      for (int p = 0; p < (fb[i] ? 2 : 4); p++) begin
        lvl = fb[i] ? (p == 1) : (p >= 2);
        for (int c = 0; c < N; c++) begin
          @(negedge clk);
          if (drv_a !== lvl) begin
            if (bad == 0) begin f_ui = ui; f_got = drv_a; f_exp = lvl; end
            bad++;
          end
          if (drv_b !== ~drv_a) cbad++;
          update = 1'b0;
          if (c == 0 && ((nupd >= 1 && ui == 3) || (nupd == 2 && ui == 9))) begin
            update = 1'b1;
            {addr, dir, speed} = (nupd == 2 && ui == 3) ? (uv ^ 15'h2A55) : uv;
          end
        end
        ui++;
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: %0d cycles wrong, first at UI %0d got %b expected %b",
               tag, bad, f_ui, f_got, f_exp);
    end
    checks++;
    if (cbad != 0) begin
      fails++;
      $display("FAIL R6 complement: %0d cycles with drv_b!=~drv_a got %0d expected 0", cbad, cbad);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [14:0] prev;
    repeat (3) @(negedge clk);
    // R9 reset level
    check_bit(drv_a === 1'b0, "R9 reset drv_a", drv_a, 1'b0);
    check_bit(drv_b === 1'b1, "R9 reset drv_b", drv_b, 1'b1);
    rst_n = 1'b1;
    // R9 default frame, R8 repeat
    run_frame(15'd0, 0, 15'd0, "R9 R1 R4 default frame");
    prev = 15'd0;
    foreach (VEC[k]) begin
      // R7 current frame untouched by mid-frame update
      run_frame(prev, 1, VEC[k], "R7 frame held during update");
      // R1 R2 R3 R4 R5 new frame content and timing
      run_frame(VEC[k], 0, 15'd0, "R1 R2 R3 R4 R5 new frame");
      prev = VEC[k];
    end
    run_frame(prev, 0, 15'd0, "R8 repeat without update");
    // R7 two pulses in one frame: last wins
    run_frame(prev, 2, {7'd10, 1'b1, 7'd100}, "R7 frame held during two updates");
    run_frame({7'd10, 1'b1, 7'd100}, 0, 15'd0, "R7 last update wins");
    run_frame({7'd10, 1'b1, 7'd100}, 0, 15'd0, "R8 repeat again");
    // R9 reset mid-frame discards pending command
    repeat (12) @(negedge clk);
    update = 1'b1; {addr, dir, speed} = {7'd9, 1'b1, 7'd9};
    @(negedge clk);
    update = 1'b0;
    repeat (25) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_bit(drv_a === 1'b0, "R9 mid-frame reset drv_a", drv_a, 1'b0);
    check_bit(drv_b === 1'b1, "R9 mid-frame reset drv_b", drv_b, 1'b1);
    rst_n = 1'b1;
    run_frame(15'd0, 0, 15'd0, "R9 restart from default frame");
    run_frame(15'd0, 0, 15'd0, "R9 pending command discarded");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule